// File: doc/BRIEF.md
# Byte-Wide Register Bank Behind a Two-Wire Serial Slave

This block lets an external two-wire (I2C) master read and write a small bank of 8-bit control registers. The bus lines enter as plain inputs. The block synchronises them to the system clock and oversamples them, and it pulls SDA low only through an open-drain enable. Every register bit is also driven out in parallel, so the logic nearby can use the settings directly.

A single address pointer serves reads and writes alike. It keeps its value between transactions. A write names the register with its first byte. A read that names no register continues from the register after the last one touched. A random read is a short write of the register number, then a repeated start with the read bit set. During a burst the pointer steps after every byte and wraps from the last register back to the first.

The controller is one state machine with these states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_SUB`: shifting in the register number.
- `ST_SUB_ACK`: acknowledging the register number.
- `ST_WDATA`: shifting in a write byte.
- `ST_WDATA_ACK`: acknowledging a write byte.
- `ST_RDATA`: shifting out a read byte.
- `ST_RDATA_ACK`: listening to the master's acknowledge.
- `ST_IGNORE`: deaf until the next start.

The transitions are as follows:
- A start moves from any state to `ST_ADDR`. A stop moves from any state to `ST_IDLE`.
- From `ST_ADDR` the machine goes to `ST_ADDR_ACK` when the address matches, and to `ST_IGNORE` when it does not.
- From `ST_ADDR_ACK` it goes to `ST_RDATA` for a read, and to `ST_SUB` for a write.
- The write path runs `ST_SUB` → `ST_SUB_ACK` → `ST_WDATA`, then loops `ST_WDATA` ↔ `ST_WDATA_ACK`.
- The read path loops `ST_RDATA` ↔ `ST_RDATA_ACK` while the master sends ACK. A master NACK moves `ST_RDATA_ACK` to `ST_IGNORE`.

Each move between two states happens on a falling SCL edge.

Top module: `regbank_i2c_slave`

## Requirements
- R1: Holding the synchronous reset clears every register to 00h, clears the pointer to 00h and releases SDA (`sda_oe` = 0).
- R2: Only an address byte whose upper seven bits equal `SLV_ADDR` is acknowledged. On any other address the slave leaves SDA released at the acknowledge bit and ignores all later bytes until the next start, so no register changes.
- R3: In a write (address bit 0 = 0), the first byte after the address is the register number. Each later byte is stored MSB first into the register at the pointer and acknowledged. Register k appears on `regs_o[8k+7:8k]` from then on.
- R4: The pointer advances by one after every data byte that is written or sent.
- R5: The pointer advances from NREG-1 (08h) to 00h. A long write burst therefore overwrites the first registers, and a long read burst returns them again.
- R6: The pointer holds its value between transactions, whether the last access was a read or a write.
- R7: A current-address read (address bit 0 = 1) sends the register at the pointer, MSB first.
- R8: A write of a register number followed by a repeated start and a read address returns data starting at that register.
- R9: A master ACK (0) after a read byte makes the slave send the next register. A master NACK (1) makes the slave stop driving SDA, and it stays released until a new start.
- R10: `sda_oe` is raised only while the synchronised SCL is low. The slave keeps SDA released during the master's acknowledge bit.
- R11: A register number of NREG (09h) or above sets the pointer to 00h.
- R12: A start or stop at any bit position abandons the byte in progress without storing it. A repeated start with no stop before it is accepted as a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| regs_o | output | NREG*8 | All registers, register k in bits 8k+7..8k |

## Verification
Storing a write byte and wrapping the pointer happen in the same system-clock cycle when a burst writes register 08h. The register at the old pointer takes the byte while the pointer jumps to 00h.

The bench provokes this with a burst that starts at register 07h and runs past the end of the bank. It judges the result from the register outputs. Register 08h must hold the second byte, and registers 00h and 01h must hold the third and fourth bytes, replacing values written earlier.

A read burst started at 08h must likewise return register 08h and then register 00h.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } i2cs_state_e;

endpackage

// File: rtl/i2cs_bus_sync.sv
module i2cs_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Idle bus level is high on both lines
    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_ff[STAGES-1];
            sda_d <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
    parameter int NREG = 9,
    parameter int AW   = $clog2(NREG)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ptr_load,
    input  logic [AW-1:0]                 ptr_val,
    input  logic                          ptr_inc,
    input  logic                          wr_en,
    input  logic [i2cs_pkg::BYTE_W-1:0]   wr_data,
    output logic [AW-1:0]                 ptr,
    output logic [i2cs_pkg::BYTE_W-1:0]   rd_data,
    output logic [NREG*i2cs_pkg::BYTE_W-1:0] regs_flat
);

    localparam int          DW   = i2cs_pkg::BYTE_W;
    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && (ptr == AW'(g))) begin
                    q <= wr_data;
                end
            end
            assign regs_flat[g*DW +: DW] = q;
        end
    endgenerate

    // Shared pointer: a load from a register number wins over a step
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ptr_load) begin
            ptr <= ptr_val;
        end else if (wr_en || ptr_inc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (ptr == AW'(i)) begin
                rd_data = regs_flat[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h2A,
    parameter int         NREG     = 9,
    parameter int         AW       = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic [AW-1:0]     ptr_val,
    output logic              ptr_inc,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output i2cs_state_e       state
);

    localparam int CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_W);

    i2cs_state_e         nxt;
    logic [CW-1:0]       bitcnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-2:0]   txsh;
    logic                rw_q;
    logic                mnack_q;
    logic                done;
    logic                addr_hit;
    logic                busy;

    assign done     = (bitcnt == FULL);
    assign addr_hit = (shreg[BYTE_W-1:1] == SLV_ADDR);
    assign busy     = ~start_det & ~stop_det;

    // Register-bank strobes, taken on the falling edge closing a byte
    assign wr_en    = busy && (state == ST_WDATA) && scl_fall && done;
    assign ptr_load = busy && (state == ST_SUB)   && scl_fall && done;
    assign ptr_inc  = busy && (state == ST_RDATA) && scl_fall && done;
    assign ptr_val  = (shreg < BYTE_W'(NREG)) ? shreg[AW-1:0] : '0;
    assign wr_data  = shreg;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_IGNORE:    nxt = ST_IGNORE;
                ST_ADDR:      if (scl_fall && done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw_q ? ST_RDATA : ST_SUB;
                ST_SUB:       if (scl_fall && done) nxt = ST_SUB_ACK;
                ST_SUB_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (scl_fall && done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && done) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = mnack_q ? ST_IGNORE : ST_RDATA;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs and bit datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '0;
            rw_q    <= 1'b0;
            mnack_q <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (!busy) begin
            bitcnt  <= '0;
            mnack_q <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise && !done) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && done) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            rw_q   <= shreg[0];
                            sda_oe <= addr_hit;
                        end else begin
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            txsh   <= rd_data[BYTE_W-2:0];
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && !done) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (done) begin
                            bitcnt <= '0;
                            sda_oe <= 1'b0;
                        end else if (bitcnt != '0) begin
                            sda_oe <= ~txsh[BYTE_W-2];
                            txsh   <= {txsh[BYTE_W-3:0], 1'b0};
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        mnack_q <= sda_s;
                    end else if (scl_fall) begin
                        if (!mnack_q) begin
                            txsh   <= rd_data[BYTE_W-2:0];
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_IDLE, ST_IGNORE: begin
                    sda_oe <= 1'b0;
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/regbank_i2c_slave.sv
module regbank_i2c_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h2A,
    parameter int         NREG        = 9,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] regs_o
);

    localparam int AW = $clog2(NREG);

    logic              scl_sync;
    logic              sda_sync;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              ptr_load;
    logic [AW-1:0]     ptr_val;
    logic              ptr_inc;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic [AW-1:0]     ptr_q;
    i2cs_state_e       st;

    i2cs_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_fsm #(
        .SLV_ADDR (SLV_ADDR),
        .NREG     (NREG),
        .AW       (AW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .ptr_load  (ptr_load),
        .ptr_val   (ptr_val),
        .ptr_inc   (ptr_inc),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .state     (st)
    );

    i2cs_regfile #(
        .NREG (NREG),
        .AW   (AW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ptr_load  (ptr_load),
        .ptr_val   (ptr_val),
        .ptr_inc   (ptr_inc),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ptr       (ptr_q),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

endmodule

// File: rtl/regbank_i2c_slave_chk.sv
module regbank_i2c_slave_chk
    import i2cs_pkg::*;
#(
    parameter int NREG = 9,
    parameter int AW   = $clog2(NREG)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_s,
    input logic                   sda_oe,
    input logic                   wr_en,
    input logic [AW-1:0]          ptr,
    input logic [NREG*BYTE_W-1:0] regs_o,
    input i2cs_state_e            state
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (regs_o == '0) && !sda_oe);

    // R10
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= AW'(NREG - 1));

    // R4
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr == (($past(ptr) == AW'(NREG - 1)) ? AW'(0) : $past(ptr) + 1'b1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(regs_o));

    // R2
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);

endmodule

bind regbank_i2c_slave regbank_i2c_slave_chk #(
    .NREG (NREG),
    .AW   (AW)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_s  (scl_sync),
    .sda_oe (sda_oe),
    .wr_en  (wr_en),
    .ptr    (ptr_q),
    .regs_o (regs_o),
    .state  (st)
);

// File: tb/tb_regbank_i2c_slave.sv
module tb_regbank_i2c_slave;

    localparam time        CLK_PERIOD = 10ns;
    localparam int         NREG = 9;
    localparam logic [6:0] SADR = 7'h2A;
    localparam int         Q = 5;
    localparam int         H = 10;
    localparam int         WD_CYCLES = 150000;
    localparam logic [15:0] VEC [4] = '{16'h035A, 16'h08C3, 16'h0096, 16'h050F};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs_o;
    wire  sda_i = sda_m & ~sda_oe;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbank_i2c_slave #(.SLV_ADDR(SADR), .NREG(NREG), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_i),
        .sda_oe(sda_oe), .regs_o(regs_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_of(input int k);
        return regs_o[k*8 +: 8];
    endfunction

    // R10: the slave may change its drive only while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe) check("R10", {31'd0, scl_m}, 32'd0);
        prev_oe = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wbit(input logic b);
        tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    endtask

    task automatic rbit(output logic b);
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_i; tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic nb;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(nb);
        ack = ~nb;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(~mack);
    endtask

    initial begin
        logic       ack;
        logic       b;
        logic [7:0] rd;

        tick(5);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        check("R1 regs", regs_o[31:0], 32'd0);
        check("R1 regs hi", {24'd0, regs_o[71:64]}, 32'd0);
        check("R1 sda_oe", {31'd0, sda_oe}, 32'd0);

        // Table: single write then random read of the same register
        for (int v = 0; v < 4; v++) begin
            bus_start();
            send_byte({SADR, 1'b0}, ack); check("R2 addr ack", {31'd0, ack}, 32'd1);
            send_byte(VEC[v][15:8], ack); check("R3 sub ack", {31'd0, ack}, 32'd1);
            send_byte(VEC[v][7:0], ack);  check("R3 data ack", {31'd0, ack}, 32'd1);
            bus_stop();
            check("R3 stored", {24'd0, reg_of(int'(VEC[v][15:8]))}, {24'd0, VEC[v][7:0]});
            bus_start();
            send_byte({SADR, 1'b0}, ack);
            send_byte(VEC[v][15:8], ack);
            bus_start();
            send_byte({SADR, 1'b1}, ack); check("R8 read addr ack", {31'd0, ack}, 32'd1);
            recv_byte(1'b0, rd);
            bus_stop();
            check("R8 random read", {24'd0, rd}, {24'd0, VEC[v][7:0]});
        end

        // R5/R4: burst from 07h runs past the end and wraps
        bus_start();
        send_byte({SADR, 1'b0}, ack);
        send_byte(8'h07, ack);
        send_byte(8'hA1, ack);
        send_byte(8'hB2, ack);
        send_byte(8'hC4, ack);
        send_byte(8'hD5, ack); check("R4 burst ack", {31'd0, ack}, 32'd1);
        bus_stop();
        check("R4 reg7", {24'd0, reg_of(7)}, 32'hA1);
        check("R5 reg8", {24'd0, reg_of(8)}, 32'hB2);
        check("R5 reg0 overwrite", {24'd0, reg_of(0)}, 32'hC4);
        check("R5 reg1", {24'd0, reg_of(1)}, 32'hD5);

        // R6/R7: current-address read continues at 02h
        bus_start();
        send_byte({SADR, 1'b1}, ack); check("R7 addr ack", {31'd0, ack}, 32'd1);
        recv_byte(1'b1, rd); check("R6 reg2", {24'd0, rd}, 32'h00);
        recv_byte(1'b1, rd); check("R9 ack continues reg3", {24'd0, rd}, 32'h5A);
        recv_byte(1'b0, rd); check("R7 reg4", {24'd0, rd}, 32'h00);
        bus_stop();
        bus_start();
        send_byte({SADR, 1'b1}, ack);
        recv_byte(1'b0, rd); check("R6 persist reg5", {24'd0, rd}, 32'h0F);
        bus_stop();

        // R5: read burst wraps from 08h to 00h
        bus_start();
        send_byte({SADR, 1'b0}, ack);
        send_byte(8'h08, ack);
        bus_start();
        send_byte({SADR, 1'b1}, ack);
        recv_byte(1'b1, rd); check("R5 read reg8", {24'd0, rd}, 32'hB2);
        recv_byte(1'b0, rd); check("R5 read wrap reg0", {24'd0, rd}, 32'hC4);
        bus_stop();

        // R9: after NACK the slave stays released
        bus_start();
        send_byte({SADR, 1'b1}, ack);
        recv_byte(1'b0, rd); check("R9 reg1", {24'd0, rd}, 32'hD5);
        rbit(b); check("R9 released after nack", {31'd0, b}, 32'd1);
        bus_stop();

        // R2: foreign address is not acknowledged and writes nothing
        bus_start();
        send_byte({SADR ^ 7'h01, 1'b0}, ack); check("R2 no ack", {31'd0, ack}, 32'd0);
        send_byte(8'h02, ack);
        send_byte(8'hEE, ack); check("R2 ignored byte", {31'd0, ack}, 32'd0);
        bus_stop();
        check("R2 reg2 untouched", {24'd0, reg_of(2)}, 32'h00);

        // R11: out-of-range register number selects 00h
        bus_start();
        send_byte({SADR, 1'b0}, ack);
        send_byte(8'h20, ack);
        send_byte(8'h44, ack);
        bus_stop();
        check("R11 reg0", {24'd0, reg_of(0)}, 32'h44);

        // R12: stop after three bits abandons the byte
        bus_start();
        send_byte({SADR, 1'b0}, ack);
        send_byte(8'h07, ack);
        wbit(1'b0); wbit(1'b1); wbit(1'b0);
        bus_stop();
        check("R12 reg7 kept", {24'd0, reg_of(7)}, 32'hA1);
        bus_start();
        send_byte({SADR, 1'b1}, ack);
        recv_byte(1'b0, rd); check("R12 pointer from aborted write", {24'd0, rd}, 32'hA1);
        bus_stop();

        // R1: reset in mid-run clears everything
        rst = 1'b1;
        tick(3);
        check("R1 clear", regs_o[31:0], 32'd0);
        check("R1 clear hi", {24'd0, regs_o[71:64]}, 32'd0);
        rst = 1'b0;
        tick(2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule